// File: doc/BRIEF.md
# Partitioned Pair-Compare Core Scheduler

This block finds the core of a decision table: the condition attributes that no other attribute can stand in for. The table is too large to keep on chip, so it is cut into `m` parts of `n` objects, and part `p` holds objects `p*n` to `(p+1)*n-1`. Two on-chip object buffers, called left and right, each hold one part. An external loader fills them. The block asks for each part and then runs a compare pass that takes every left object against every right object, one pair per clock.

Only the upper triangle of part pairs is visited. At the start of outer step `i`, one load writes part `i` into both buffers. For each later part `j` (`j` from `i+1` to `m-1`), only the right buffer is reloaded, with part `j`. A pair adds to the core only when the two decisions differ and exactly one condition attribute differs; that attribute's bit is then set. The core mask is cleared at start and grows by OR over every pass.

Each object word is `in_data`: attribute `k` sits in bits `[k*ATTR_W +: ATTR_W]`, and the decision sits in the top `DEC_W` bits. Object words enter on a valid/ready stream. A word moves on a cycle in which `in_valid` and `in_ready` are both high. The loader may hold `in_valid` low at any time. `in_ready` is high only while a load request is open and fewer than `n` words have been taken, so the block applies back-pressure by dropping ready. A loader that keeps `in_valid` high with more data past that point is simply stalled. The loader must deliver exactly `n` words, then pulse `load_done`.

Top module: `core_pair_sched`

## Requirements
- R1: After reset, `busy`, `done`, `load_req` and `in_ready` are low and `core_mask` is zero.
- R2: `cfg_parts` and `cfg_objs` are captured in the cycle `start` is accepted, and a value of zero is taken as one. Changing them later has no effect on the running job.
- R3: The loads come in this order: for each outer index `i` from 0 to m-1, first one load with `load_sel`=2'b11 (both buffers) and `load_part`=i, then one load with `load_sel`=2'b10 (right buffer only) for each part j from i+1 to m-1, in rising order.
- R4: `load_req`, `load_sel` and `load_part` hold steady until `load_done`. `in_ready` is high only while `load_req` is high, and it falls once `n` words have been accepted in that load.
- R5: After the cycle in which `load_done` is taken, `load_req` and `done` stay low for exactly n*n+1 cycles. The next load request, or `done`, appears in the cycle after that.
- R6: A left/right pair sets core bit k only if the two decision fields differ and attribute k is the single attribute field that differs. Pairs with equal decisions never set a bit.
- R7: `start` clears `core_mask`. During a job, bits are only ever added, and after each pass `core_mask` is the OR of all pairs compared so far. It holds its value after the job ends.
- R8: `done` is high for exactly one cycle after the last pass (outer and inner index both m-1). `busy` is low in that cycle.
- R9: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; taken only when idle |
| cfg_parts | input | PW | Number of parts m (0 means 1) |
| cfg_objs | input | NW | Objects per part n, 1..PART_MAX (0 means 1) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when the job has finished |
| load_req | output | 1 | Load request open |
| load_sel | output | 2 | Target buffers: bit0 left, bit1 right |
| load_part | output | PW | Part index to load |
| load_done | input | 1 | Loader has delivered all words of the request |
| in_valid | input | 1 | Object word on `in_data` is valid |
| in_ready | output | 1 | Block accepts an object word this cycle |
| in_data | input | OBJ_W | Object word: attributes low, decision high |
| core_mask | output | N_ATTR | Accumulated core, one bit per attribute |

## Verification
The bench targets the smallest job, where zero configuration values become one part of one object. A design that does not clamp them either hangs or makes an empty pass. It checks the load order for the triangle of parts. A design that reloads both buffers on every step, or starts the inner index at zero, sends the wrong buffer select or part index. A second start during a pass, together with configuration inputs changed after capture, shows whether the job restarts or re-reads live settings. The core tables are built so that a single-attribute difference appears between equal decisions, and a lone qualifying pair sits in two parts far apart. A wrong decision test, a rule that accepts two differences, or a missed cross-part pass then gives the wrong mask.

// File: rtl/pairsched_pkg.sv
package pairsched_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PASS, ST_DRAIN} sched_st_t;
  localparam logic [1:0] SEL_RIGHT = 2'b10;
  localparam logic [1:0] SEL_BOTH  = 2'b11;
endpackage

// File: rtl/ps_obj_buf.sv
module ps_obj_buf #(
  parameter int W     = 18,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // synchronous read: data for raddr appears one cycle later
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ps_pair_eval.sv
module ps_pair_eval #(
  parameter int N_ATTR = 4,
  parameter int ATTR_W = 4,
  parameter int DEC_W  = 2,
  localparam int OBJ_W = N_ATTR * ATTR_W + DEC_W
) (
  input  logic [OBJ_W-1:0]  obj_l,
  input  logic [OBJ_W-1:0]  obj_r,
  output logic [N_ATTR-1:0] contrib
);
  logic [N_ATTR-1:0] adiff;
  logic              dec_diff;
  logic              single;

  for (genvar k = 0; k < N_ATTR; k++) begin : g_attr
    assign adiff[k] = obj_l[k*ATTR_W +: ATTR_W] != obj_r[k*ATTR_W +: ATTR_W];
  end

  assign dec_diff = obj_l[OBJ_W-1 -: DEC_W] != obj_r[OBJ_W-1 -: DEC_W];
  // exactly one differing attribute: nonzero with a single set bit
  assign single   = (adiff != '0) && ((adiff & (adiff - 1'b1)) == '0);
  assign contrib  = (dec_diff && single) ? adiff : '0;
endmodule

// File: rtl/ps_seq_ctrl.sv
module ps_seq_ctrl
  import pairsched_pkg::*;
#(
  parameter int PART_MAX = 8,
  parameter int PW       = 4,
  localparam int NW      = $clog2(PART_MAX + 1),
  localparam int AW      = (PART_MAX > 1) ? $clog2(PART_MAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] cfg_parts,
  input  logic [NW-1:0] cfg_objs,
  input  logic          load_done,
  input  logic          in_valid,
  output logic          busy,
  output logic          done,
  output logic          load_req,
  output logic [1:0]    load_sel,
  output logic [PW-1:0] load_part,
  output logic          in_ready,
  output logic [1:0]    wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr_l,
  output logic [AW-1:0] rd_addr_r,
  output logic          pair_vld,
  output logic          core_clr
);
  sched_st_t     st;
  logic [PW-1:0] m_q, outer_q, inner_q;
  logic [NW-1:0] n_q, wcnt;
  logic [AW-1:0] xa, ya;
  logic [1:0]    sel_q;
  logic          done_q, pv_q;
  logic          start_ok, x_last, y_last, inner_last, outer_last;

  assign start_ok   = (st == ST_IDLE) && start;
  assign x_last     = (NW'(xa) == n_q - 1'b1);
  assign y_last     = (NW'(ya) == n_q - 1'b1);
  assign inner_last = (inner_q == m_q - 1'b1);
  assign outer_last = (outer_q == m_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      m_q     <= '0;
      n_q     <= '0;
      outer_q <= '0;
      inner_q <= '0;
      wcnt    <= '0;
      xa      <= '0;
      ya      <= '0;
      sel_q   <= SEL_BOTH;
      done_q  <= 1'b0;
      pv_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pv_q   <= (st == ST_PASS);
      unique case (st)
        ST_IDLE: if (start_ok) begin
          m_q     <= (cfg_parts == '0) ? PW'(1) : cfg_parts;
          n_q     <= (cfg_objs == '0) ? NW'(1) : cfg_objs;
          outer_q <= '0;
          inner_q <= '0;
          sel_q   <= SEL_BOTH;
          wcnt    <= '0;
          st      <= ST_LOAD;
        end
        ST_LOAD: begin
          if (in_valid && in_ready) wcnt <= wcnt + 1'b1;
          if (load_done) begin
            xa <= '0;
            ya <= '0;
            st <= ST_PASS;
          end
        end
        ST_PASS: begin
          if (y_last) begin
            ya <= '0;
            if (x_last) st <= ST_DRAIN;
            else        xa <= xa + 1'b1;
          end else begin
            ya <= ya + 1'b1;
          end
        end
        ST_DRAIN: begin
          wcnt <= '0;
          if (inner_last) begin
            if (outer_last) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              outer_q <= outer_q + 1'b1;
              inner_q <= outer_q + 1'b1;
              sel_q   <= SEL_BOTH;
              st      <= ST_LOAD;
            end
          end else begin
            inner_q <= inner_q + 1'b1;
            sel_q   <= SEL_RIGHT;
            st      <= ST_LOAD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign load_req  = (st == ST_LOAD);
  assign load_sel  = sel_q;
  assign load_part = inner_q;
  assign in_ready  = (st == ST_LOAD) && (wcnt < n_q);
  assign wr_en     = {2{in_valid && in_ready}} & sel_q;
  assign wr_addr   = wcnt[AW-1:0];
  assign rd_addr_l = xa;
  assign rd_addr_r = ya;
  assign pair_vld  = pv_q;
  assign core_clr  = start_ok;

  // R4: request fields stay put until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !load_done) |=> (load_req && $stable(load_part) && $stable(load_sel)));

  // R4: words accepted only inside an open request
  p_ready_in_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> load_req);

  // R3: a right-only reload always targets a later part within range
  p_right_part_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && load_sel == SEL_RIGHT) |-> (load_part > outer_q && load_part < m_q));

  // R8: completion pulse only when idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !load_req));

  // R9: a start while busy leaves the configuration untouched
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(m_q) && $stable(n_q)));
endmodule

// File: rtl/core_pair_sched.sv
module core_pair_sched #(
  parameter int N_ATTR   = 4,
  parameter int ATTR_W   = 4,
  parameter int DEC_W    = 2,
  parameter int PART_MAX = 8,
  parameter int PW       = 4,
  localparam int OBJ_W   = N_ATTR * ATTR_W + DEC_W,
  localparam int NW      = $clog2(PART_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PW-1:0]     cfg_parts,
  input  logic [NW-1:0]     cfg_objs,
  output logic              busy,
  output logic              done,
  output logic              load_req,
  output logic [1:0]        load_sel,
  output logic [PW-1:0]     load_part,
  input  logic              load_done,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OBJ_W-1:0]  in_data,
  output logic [N_ATTR-1:0] core_mask
);
  localparam int AW = (PART_MAX > 1) ? $clog2(PART_MAX) : 1;

  logic [1:0]        wr_en;
  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     rd_addr [2];
  logic [OBJ_W-1:0]  rd_data [2];
  logic              pair_vld, core_clr;
  logic [N_ATTR-1:0] contrib, core_q;

  ps_seq_ctrl #(.PART_MAX(PART_MAX), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_parts(cfg_parts), .cfg_objs(cfg_objs),
    .load_done(load_done), .in_valid(in_valid),
    .busy(busy), .done(done), .load_req(load_req),
    .load_sel(load_sel), .load_part(load_part), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr_l(rd_addr[0]), .rd_addr_r(rd_addr[1]),
    .pair_vld(pair_vld), .core_clr(core_clr)
  );

  // buffer 0 = left (outer objects), buffer 1 = right (inner objects)
  for (genvar g = 0; g < 2; g++) begin : g_buf
    ps_obj_buf #(.W(OBJ_W), .DEPTH(PART_MAX), .AW(AW)) u_buf (
      .clk(clk), .we(wr_en[g]), .waddr(wr_addr), .wdata(in_data),
      .raddr(rd_addr[g]), .rdata(rd_data[g])
    );
  end

  ps_pair_eval #(.N_ATTR(N_ATTR), .ATTR_W(ATTR_W), .DEC_W(DEC_W)) u_eval (
    .obj_l(rd_data[0]), .obj_r(rd_data[1]), .contrib(contrib)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        core_q <= '0;
    else if (core_clr) core_q <= '0;
    else if (pair_vld) core_q <= core_q | contrib;
  end

  assign core_mask = core_q;

  // R6: an evaluated pair names at most one attribute
  p_single_attr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |-> $onehot0(contrib));

  // R7: start empties the mask
  p_core_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_clr |=> (core_mask == '0));

  // R7: while a job runs, bits are only added
  p_core_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((core_mask & $past(core_mask)) == $past(core_mask)));
endmodule

// File: tb/sim_core_pair_sched.sv
module sim_core_pair_sched;
  localparam int NA = 4, AWD = 4, DW = 2, PMAX = 8, PW = 4, NW = 4;
  localparam int OW = NA * AWD + DW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start, load_done, in_valid;
  logic [PW-1:0] cfg_parts;
  logic [NW-1:0] cfg_objs;
  logic          busy, done, load_req, in_ready;
  logic [1:0]    load_sel;
  logic [PW-1:0] load_part;
  logic [OW-1:0] in_data;
  logic [NA-1:0] core_mask;

  core_pair_sched #(.N_ATTR(NA), .ATTR_W(AWD), .DEC_W(DW), .PART_MAX(PMAX), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_parts(cfg_parts), .cfg_objs(cfg_objs),
    .busy(busy), .done(done), .load_req(load_req), .load_sel(load_sel),
    .load_part(load_part), .load_done(load_done), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .core_mask(core_mask)
  );

  int checks = 0, fails = 0;
  logic [OW-1:0] tbl [64];
  logic [NA-1:0] exp_core;
  int unsigned   lcg = 32'd7;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return (lcg >> 16) & 32'h7fff;
  endfunction

  // behavioural pair rule: different decisions and exactly one differing attribute
  function automatic logic [NA-1:0] pair_bits(input logic [OW-1:0] a, input logic [OW-1:0] b);
    int cnt = 0, idx = 0;
    if (a[OW-1 -: DW] == b[OW-1 -: DW]) return '0;
    for (int k = 0; k < NA; k++)
      if (a[k*AWD +: AWD] != b[k*AWD +: AWD]) begin cnt++; idx = k; end
    if (cnt != 1) return '0;
    return NA'(1) << idx;
  endfunction

  function automatic logic [NA-1:0] pass_mask(input int pi, input int pj, input int n);
    logic [NA-1:0] acc = '0;
    for (int x = 0; x < n; x++)
      for (int y = 0; y < n; y++)
        acc |= pair_bits(tbl[pi*n + x], tbl[pj*n + y]);
    return acc;
  endfunction

  // attributes 0..2 toggle between 0 and 1, attribute 3 fixed; decision random or fixed
  task automatic fill_table(input bit fixed_dec);
    for (int e = 0; e < 64; e++) begin
      logic [OW-1:0] w = '0;
      for (int k = 0; k < 3; k++) w[k*AWD +: AWD] = AWD'(rnd() % 2);
      w[3*AWD +: AWD] = 4'h9;
      w[OW-1 -: DW] = fixed_dec ? 2'd0 : DW'(rnd() % 2);
      tbl[e] = w;
    end
  endtask

  // one qualifying pair only: object 1 (part 0) against object 10 (part 3), attribute 2
  task automatic fill_far_pair();
    for (int e = 0; e < 64; e++) tbl[e] = {2'd0, 16'h5555};
    tbl[1]  = {2'd1, 16'h0000};
    tbl[10] = {2'd0, 16'h0700};
  endtask

  task automatic run_job(input int m, input int n, input int gap, input bit poke);
    int mm, nn, cnt, guard;
    mm = (m == 0) ? 1 : m;
    nn = (n == 0) ? 1 : n;
    exp_core = '0;
    cfg_parts = PW'(m);
    cfg_objs  = NW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin cfg_parts = PW'(2); cfg_objs = NW'(1); end  // R2: late change
    for (int i = 0; i < mm; i++) begin
      for (int j = i; j < mm; j++) begin
        chk(load_req == 1'b1, "R3", "load_req", int'(load_req), 1);
        chk(load_sel == ((j == i) ? 2'b11 : 2'b10), "R3", "load_sel", int'(load_sel), (j == i) ? 3 : 2);
        chk(int'(load_part) == j, "R3", "load_part", int'(load_part), j);
        @(negedge clk);
        chk(load_req && int'(load_part) == j, "R4", "request held", int'(load_part), j);
        for (int w = 0; w < nn; w++) begin
          if ((w + gap) % 3 == 0) begin in_valid = 1'b0; @(negedge clk); end
          in_valid = 1'b1;
          in_data  = tbl[j*nn + w];
          guard = 0;
          while (!in_ready && guard < 50) begin @(negedge clk); guard++; end
          @(negedge clk);
        end
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R4", "in_ready after n words", int'(in_ready), 0);
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
        cnt = 0;
        while (!load_req && !done && cnt < 1000) begin
          start = (poke && i == 0 && j == 0 && cnt == 2);  // R9: start mid-pass
          cnt++;
          @(negedge clk);
        end
        start = 1'b0;
        chk(cnt == nn*nn + 1, "R5", "quiet cycles of pass", cnt, nn*nn + 1);
        exp_core |= pass_mask(i, j, nn);
        chk(core_mask == exp_core, "R6", "core after pass", int'(core_mask), int'(exp_core));
        chk(done == (i == mm-1 && j == mm-1), "R8", "done timing", int'(done), int'(i == mm-1 && j == mm-1));
      end
    end
    chk(busy == 1'b0, "R8", "busy with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", int'(done), 0);
    chk(core_mask == exp_core, "R7", "core held", int'(core_mask), int'(exp_core));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; load_done = 1'b0; in_valid = 1'b0;
    in_data = '0; cfg_parts = '0; cfg_objs = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !load_req && !in_ready, "R1", "idle outputs", int'({busy, done, load_req, in_ready}), 0);
    chk(core_mask == '0, "R1", "core reset", int'(core_mask), 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill_table(1'b0);
    run_job(0, 0, 1, 1'b0);          // R2: zero means one part of one object
    run_job(3, 4, 0, 1'b1);          // R2, R9: late config change and stray start
    chk(core_mask[3] == 1'b0, "R6", "constant attribute never in core", int'(core_mask[3]), 0);
    fill_table(1'b1);
    run_job(2, PMAX, 2, 1'b0);       // R6: equal decisions, full part size
    fill_far_pair();
    run_job(4, 3, 1, 1'b0);          // R7: lone pair across distant parts
    chk(core_mask == 4'b0100, "R7", "far pair core", int'(core_mask), 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule